// File: doc/BRIEF.md
# DRAM Fast-Page Access Sequencer

This block sits between a simple CPU-side request port and a 16-bit asynchronous DRAM. Each accepted request (address, read or write, two byte enables, write data and a per-request wait count) becomes a sequence of DRAM bus phases. The block drives an active-low row strobe, separate active-low upper and lower column strobes, an active-low write enable, a multiplexed row/column address and the write data with its output enable. It also captures read data.

A full access opens a row from scratch: precharge, row address, first column phase, optional wait phases, second column phase. When burst operation is enabled and the next request arrives back to back and falls in the row that is already open, the row strobe stays low and only the column phases repeat. The split of the address into row and column depends on a column-width setting and on whether the memory is 8 or 16 bits wide. The row comparison uses the same split.

A request is held on the input until it is accepted, which happens on a clock edge where both `req_valid` and `req_ready` are high. The configuration inputs are expected to stay static while accesses are in flight.

Top module: `dram_page_ctrl`

## Requirements
- R1: An access started from idle, or one that is not a burst hit, runs one cycle in each of precharge (ras_n high), row (ras_n low, ma = row) and column-1 (ras_n low, ma = column, both CAS high), then 0 to 3 wait cycles, then one column-2 cycle. The first of these cycles is the cycle after acceptance.
- R2: While cfg_burst_en is 0, every access is a full access with its own precharge and row cycles, even when it hits the open row.
- R3: While cfg_burst_en is 1, a request accepted in the column-2 cycle whose row equals the open row continues directly with column-1 in the next cycle. ras_n stays low throughout.
- R4: A row miss, or a cycle with no request at the end of column-2, closes the row. ras_n goes high, and the next access starts with a precharge cycle.
- R5: The number of wait cycles between column-1 and column-2 equals the request's req_wait value (0 to 3). The same rule applies in full and burst accesses, and ma holds the column through them.
- R6: CAS is asserted (low) only in wait and column-2 cycles. With cfg_bus16=1, ucas_n follows req_be[1] and lcas_n follows req_be[0]. With cfg_bus16=0, lcas_n alone is used and ucas_n stays high.
- R7: For a write, we_n is low and dq_oe is high in column-1, wait and column-2 cycles, with dq_o equal to the write data. For a read, we_n stays high and dq_oe low.
- R8: The address is first shifted right by one when cfg_bus16=1. The column width is 8 + cfg_col_sel bits: the column is the low bits of the shifted address and the row is the remaining upper bits. ma shows the low MAW bits of the row, or the column. The whole row is used for the hit comparison.
- R9: Read data on dq_i is captured at the end of column-2 and appears on rdata in the next cycle. done pulses for exactly that one cycle after every access.
- R10: req_ready is high only in idle and in column-2 cycles. After reset the block is idle with ras_n, ucas_n, lcas_n and we_n high, done low and dq_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_en | input | 1 | Enables same-row burst continuation |
| cfg_col_sel | input | 2 | Column width select, 8 + value bits |
| cfg_bus16 | input | 1 | 1 = 16-bit memory, 0 = 8-bit memory |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte lane enables (bit 1 upper, bit 0 lower) |
| req_wdata | input | DW | Write data |
| req_wait | input | WAITW | Wait cycles to insert before column-2 |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-lane column strobe, active low |
| lcas_n | output | 1 | Lower-lane column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ma | output | MAW | Multiplexed row/column address |
| dq_o | output | DW | Write data to memory |
| dq_oe | output | 1 | Drive enable for dq_o |
| dq_i | input | DW | Read data from memory |
| rdata | output | DW | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check these properties on every cycle:
- column strobes occur only inside an active row strobe;
- the upper strobe stays quiet on an 8-bit memory;
- the column address holds while CAS stays low;
- done never lasts two cycles;
- a request accepted from idle begins with a precharge;
- the write enable falls only while a row is open.

Only the bench scenarios can show the properties that depend on the whole access:
- the exact phase sequence per access;
- whether a chained request is correctly recognised as a hit or a miss under each column width and bus width;
- the wait count;
- the captured read data.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    localparam int MIN_COL_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_ROW  = 3'd2,
        ST_COL1 = 3'd3,
        ST_WAIT = 3'd4,
        ST_COL2 = 3'd5
    } dpc_state_e;

    typedef struct packed {
        logic row_act;   // row strobe active
        logic cas_act;   // column strobes may be active
        logic col_ph;    // address mux shows the column
        logic wr_ph;     // write enable / data drive window
        logic row_ph;    // address mux shows the row
    } dpc_strobe_t;

    function automatic dpc_strobe_t phase_strobes(dpc_state_e st);
        dpc_strobe_t s;
        s = '0;
        case (st)
            ST_PRE:  s.row_ph = 1'b1;
            ST_ROW:  begin s.row_ph = 1'b1; s.row_act = 1'b1; end
            ST_COL1: begin s.row_act = 1'b1; s.col_ph = 1'b1; s.wr_ph = 1'b1; end
            ST_WAIT,
            ST_COL2: begin
                s.row_act = 1'b1; s.cas_act = 1'b1;
                s.col_ph = 1'b1; s.wr_ph = 1'b1;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic logic [3:0] col_bits(logic [1:0] sel);
        return 4'(MIN_COL_BITS) + {2'b00, sel};
    endfunction

endpackage

// File: rtl/dpc_addr_split.sv
module dpc_addr_split
    import dpc_pkg::*;
#(
    parameter int AW  = 24,
    parameter int MAW = 12
) (
    input  logic [AW-1:0]  addr,
    input  logic           bus16,
    input  logic [1:0]     col_sel,
    output logic [AW-1:0]  row,
    output logic [MAW-1:0] col
);
    logic [AW-1:0] shifted;
    logic [AW-1:0] mask;
    logic [AW-1:0] col_full;
    logic [3:0]    cb;

    always_comb begin
        cb       = col_bits(col_sel);
        shifted  = bus16 ? (addr >> 1) : addr;
        mask     = (AW'(1) << cb) - AW'(1);
        col_full = shifted & mask;
        row      = shifted >> cb;
        col      = col_full[MAW-1:0];
    end
endmodule

// File: rtl/dpc_row_track.sv
module dpc_row_track #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open_set,
    input  logic          open_clr,
    input  logic [AW-1:0] row_in,
    input  logic [AW-1:0] cmp_row,
    output logic          hit
);
    logic          open_vld;
    logic [AW-1:0] open_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_vld <= 1'b0;
            open_row <= '0;
        end else if (open_clr) begin
            open_vld <= 1'b0;
        end else if (open_set) begin
            open_vld <= 1'b1;
            open_row <= row_in;
        end
    end

    assign hit = open_vld && (cmp_row == open_row);
endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
    import dpc_pkg::*;
#(
    parameter int WAITW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic             burst_hit,
    input  logic [WAITW-1:0] wait_in,
    output dpc_state_e       state,
    output logic             ready,
    output logic             open_set,
    output logic             open_clr
);
    dpc_state_e       nxt;
    logic [WAITW-1:0] wcnt;

    always_comb begin
        ready    = (state == ST_IDLE) || (state == ST_COL2);
        open_set = (state == ST_ROW);
        open_clr = (state == ST_COL2) && !(acc && burst_hit);
        nxt      = state;
        case (state)
            ST_IDLE: if (acc) nxt = ST_PRE;
            ST_PRE:  nxt = ST_ROW;
            ST_ROW:  nxt = ST_COL1;
            ST_COL1: nxt = (wcnt != '0) ? ST_WAIT : ST_COL2;
            ST_WAIT: if (wcnt == WAITW'(1)) nxt = ST_COL2;
            ST_COL2: begin
                if (!acc)          nxt = ST_IDLE;
                else if (burst_hit) nxt = ST_COL1;
                else               nxt = ST_PRE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            wcnt  <= '0;
        end else begin
            state <= nxt;
            if (acc)
                wcnt <= wait_in;
            else if (state == ST_WAIT)
                wcnt <= wcnt - WAITW'(1);
        end
    end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dpc_pkg::*;
#(
    parameter int AW    = 24,
    parameter int DW    = 16,
    parameter int MAW   = 12,
    parameter int WAITW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_burst_en,
    input  logic [1:0]       cfg_col_sel,
    input  logic             cfg_bus16,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    input  logic [1:0]       req_be,
    input  logic [DW-1:0]    req_wdata,
    input  logic [WAITW-1:0] req_wait,
    output logic             ras_n,
    output logic             ucas_n,
    output logic             lcas_n,
    output logic             we_n,
    output logic [MAW-1:0]   ma,
    output logic [DW-1:0]    dq_o,
    output logic             dq_oe,
    input  logic [DW-1:0]    dq_i,
    output logic [DW-1:0]    rdata,
    output logic             done
);
    dpc_state_e     state;
    dpc_strobe_t    stb;
    logic           acc, row_hit, burst_hit, open_set, open_clr;
    logic [AW-1:0]  nxt_row, cur_row;
    logic [MAW-1:0] nxt_col, cur_col;
    logic           cur_write;
    logic [1:0]     cur_be;
    logic [DW-1:0]  cur_wdata;

    dpc_addr_split #(.AW(AW), .MAW(MAW)) u_split (
        .addr    (req_addr),
        .bus16   (cfg_bus16),
        .col_sel (cfg_col_sel),
        .row     (nxt_row),
        .col     (nxt_col)
    );

    dpc_row_track #(.AW(AW)) u_track (
        .clk      (clk),
        .rst      (rst),
        .open_set (open_set),
        .open_clr (open_clr),
        .row_in   (cur_row),
        .cmp_row  (nxt_row),
        .hit      (row_hit)
    );

    assign acc       = req_valid && req_ready;
    assign burst_hit = cfg_burst_en && row_hit;

    dpc_seq #(.WAITW(WAITW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .burst_hit (burst_hit),
        .wait_in   (req_wait),
        .state     (state),
        .ready     (req_ready),
        .open_set  (open_set),
        .open_clr  (open_clr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_row   <= '0;
            cur_col   <= '0;
            cur_write <= 1'b0;
            cur_be    <= '0;
            cur_wdata <= '0;
            rdata     <= '0;
            done      <= 1'b0;
        end else begin
            if (acc) begin
                cur_row   <= nxt_row;
                cur_col   <= nxt_col;
                cur_write <= req_write;
                cur_be    <= req_be;
                cur_wdata <= req_wdata;
            end
            done <= (state == ST_COL2);
            if (state == ST_COL2 && !cur_write)
                rdata <= dq_i;
        end
    end

    always_comb begin
        stb    = phase_strobes(state);
        ras_n  = !stb.row_act;
        ucas_n = !(stb.cas_act && cfg_bus16 && cur_be[1]);
        lcas_n = !(stb.cas_act && (!cfg_bus16 || cur_be[0]));
        we_n   = !(stb.wr_ph && cur_write);
        dq_oe  = stb.wr_ph && cur_write;
        dq_o   = cur_wdata;
        if (stb.col_ph)
            ma = cur_col;
        else if (stb.row_ph)
            ma = cur_row[MAW-1:0];
        else
            ma = '0;
    end
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
    parameter int MAW = 12
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_bus16,
    input logic           req_valid,
    input logic           req_ready,
    input logic           ras_n,
    input logic           ucas_n,
    input logic           lcas_n,
    input logic           we_n,
    input logic [MAW-1:0] ma,
    input logic           done
);
    p_cas_inside_ras_r6: assert property (@(posedge clk) disable iff (rst)
        (!ucas_n || !lcas_n) |-> !ras_n);

    p_upper_quiet_narrow_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_bus16 |-> ucas_n);

    p_col_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!lcas_n && !$past(lcas_n)) |-> $stable(ma));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_start_precharge_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ras_n) |=> ras_n);

    p_write_in_row_r7: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ras_n);
endmodule

bind dram_page_ctrl dpc_checker #(.MAW(MAW)) u_chk (.*);

// File: tb/dram_page_ctrl_test.sv
module dram_page_ctrl_test;
    localparam int AW = 24, DW = 16, MAW = 12, WAITW = 2;
    localparam int P_PRE = 0, P_ROW = 1, P_C1 = 2, P_W = 3, P_C2 = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_burst_en = 0, cfg_bus16 = 0;
    logic [1:0] cfg_col_sel = 0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_be = '0;
    logic [DW-1:0] req_wdata = '0, dq_i = '0;
    logic [WAITW-1:0] req_wait = '0;
    logic req_ready, ras_n, ucas_n, lcas_n, we_n, dq_oe, done;
    logic [MAW-1:0] ma;
    logic [DW-1:0] dq_o, rdata;

    int n_chk = 0, n_fail = 0;
    bit chained = 0, pend = 0, pend_rd = 0;
    logic [AW-1:0] prev_row = '0;
    logic [DW-1:0] pend_data = '0;
    bit c_wr; logic [1:0] c_be; logic [AW-1:0] c_row; logic [MAW-1:0] c_col;
    logic [DW-1:0] c_wd;

    always #4 clk = ~clk;

    dram_page_ctrl #(.AW(AW), .DW(DW), .MAW(MAW), .WAITW(WAITW)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_phase(input int p, input string ras_tag);
        bit cas, wr;
        logic [MAW-1:0] exp_ma;
        cas = (p == P_W) || (p == P_C2);
        wr  = c_wr && (p >= P_C1);
        exp_ma = (p <= P_ROW) ? c_row[MAW-1:0] : c_col;
        chk({ras_tag, " ras_n"}, 32'(ras_n), 32'(p != P_ROW && p != P_C1 && p != P_W && p != P_C2));
        chk("R6 ucas_n", 32'(ucas_n), 32'(!(cas && cfg_bus16 && c_be[1])));
        chk("R6 lcas_n", 32'(lcas_n), 32'(!(cas && (!cfg_bus16 || c_be[0]))));
        chk("R7 we_n", 32'(we_n), 32'(!wr));
        chk("R7 dq_oe", 32'(dq_oe), 32'(wr));
        chk("R8 ma", 32'(ma), 32'(exp_ma));
        chk("R10 ready", 32'(req_ready), 32'(p == P_C2));
        if (wr) chk("R7 dq_o", 32'(dq_o), 32'(c_wd));
    endtask

    task automatic check_done();
        chk("R9 done", 32'(done), 32'(pend));
        if (pend && pend_rd) chk("R9 rdata", 32'(rdata), 32'(pend_data));
        pend = 0;
    endtask

    task automatic access(input logic [AW-1:0] a, input bit wr, input logic [1:0] be,
                          input logic [DW-1:0] wd, input int wt, input bit last);
        logic [AW-1:0] sh;
        int cb;
        bit hit;
        cb = 8 + int'(cfg_col_sel);
        sh = cfg_bus16 ? (a >> 1) : a;
        c_row = sh >> cb;
        c_col = MAW'(sh & ((AW'(1) << cb) - 1));
        c_wr = wr; c_be = be; c_wd = wd;
        hit = cfg_burst_en && chained && (c_row == prev_row);
        chk("R10 ready at issue", 32'(req_ready), 32'd1);
        req_valid = 1; req_addr = a; req_write = wr; req_be = be;
        req_wdata = wd; req_wait = WAITW'(wt);
        @(negedge clk);
        check_done();
        if (!hit) begin
            check_phase(P_PRE, chained ? (cfg_burst_en ? "R4" : "R2") : "R1");
            @(negedge clk);
            check_phase(P_ROW, "R1");
            @(negedge clk);
        end
        check_phase(P_C1, hit ? "R3" : "R1");
        @(negedge clk);
        for (int i = 0; i < wt; i++) begin
            check_phase(P_W, "R5");
            @(negedge clk);
        end
        check_phase(P_C2, "R5");
        pend_data = 16'hA000 ^ DW'(a[11:0]) ^ (wr ? 16'h0 : 16'h0F0F);
        dq_i = pend_data;
        pend = 1; pend_rd = !wr;
        req_valid = 0;
        chained = !last;
        prev_row = c_row;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_done();
            chk("R4 ras_n idle", 32'(ras_n), 32'd1);
            chk("R6 lcas_n idle", 32'(lcas_n), 32'd1);
        end
        chained = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [AW-1:0] base, step;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R10 reset ras_n", 32'(ras_n), 32'd1);
        chk("R10 reset ucas_n", 32'(ucas_n), 32'd1);
        chk("R10 reset lcas_n", 32'(lcas_n), 32'd1);
        chk("R10 reset we_n", 32'(we_n), 32'd1);
        chk("R10 reset done", 32'(done), 32'd0);
        chk("R10 reset dq_oe", 32'(dq_oe), 32'd0);
        chk("R10 reset ready", 32'(req_ready), 32'd1);
        for (int be_ = 0; be_ < 2; be_++)
            for (int b16 = 0; b16 < 2; b16++)
                for (int cs = 0; cs < 4; cs++) begin
                    cfg_burst_en = be_[0]; cfg_bus16 = b16[0]; cfg_col_sel = cs[1:0];
                    step = AW'(1) << (8 + cs + b16);
                    base = 24'h6B0000 + AW'(cs * 5 + b16 + 3) * step;
                    access(base + 24'h10, 0, 2'b11, 16'h0, 0, 0);
                    access(base + 24'h14, 1, 2'b01, 16'h1234 + 16'(cs), 1, 0);
                    access(base + 24'h22, 1, 2'b10, 16'hBEEF, 3, 0);
                    access(base + step + 24'h10, 0, 2'b11, 16'h0, 2, 0);
                    access(base + step + 24'h30, 0, 2'b01, 16'h0, 0, 1);
                    idle(2);
                    access(base + step + 24'h30, 1, 2'b11, 16'h5A5A, 0, 1);
                    idle(1);
                end
        cfg_burst_en = 1; cfg_bus16 = 1; cfg_col_sel = 2'd1;
        for (int wt = 0; wt < 4; wt++)
            access(24'h123400 + AW'(wt * 4), wt[0], 2'b11, 16'h7700 + 16'(wt), wt, wt == 3);
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule